// File: doc/BRIEF.md
# ALU Status Flag Unit

This block is an 8-bit arithmetic and logic unit joined to a status register. On each accepted operation it computes a result from two operands and, at the same clock edge, records six condition flags that describe that result: carry (or borrow), carry out of the low nibble, odd-ones parity, zero, sign and signed overflow. Later instructions can test these flags to steer control flow.

The same register also keeps three control bits: the string stepping direction, the external interrupt enable and the single-step request. Arithmetic never touches them. Software-side logic changes them only through per-bit set and clear command lines, which act in any cycle, with or without an operation. Decode of instructions, multi-byte chains and decimal adjust belong to neighbouring blocks.

Top module: `alu_status_unit`

## Requirements
- R1: Opcode `op_i` encodes 0 ADD (a+b), 1 SUB (a-b), 2 AND, 3 OR, 4 XOR, each result taken modulo 256 and presented on `result_o` one clock edge after the operation is accepted.
- R2: After ADD the carry flag is the carry out of bit 7; after SUB it is 1 exactly when a < b unsigned (borrow).
- R3: The auxiliary flag is the carry out of bit 3 into bit 4 for ADD (low nibbles sum above 15) and the borrow into bit 4 for SUB (low nibble of a below that of b).
- R4: The overflow flag is 1 when the signed result of ADD or SUB falls outside -128..127.
- R5: The zero flag is 1 exactly when the new result is 0, and the sign flag copies result bit 7.
- R6: The parity flag is 1 when the new result has an odd number of 1 bits and 0 when the count is even.
- R7: AND, OR and XOR clear the carry, auxiliary and overflow flags.
- R8: Opcodes 5 SHL, 6 SHR, 7 ROL and 8 ROR move operand a by one place (b is ignored, shifts fill with 0); carry takes the bit moved out (bit 7 for SHL/ROL, bit 0 for SHR/ROR), auxiliary and overflow are cleared.
- R9: Result and the six condition flags change only at the edge after `valid_i` is high with an opcode 0..8; with `valid_i` low or an opcode 9..15 they hold their values.
- R10: Control bit index 0 direction, 1 interrupt enable, 2 single-step: `ctl_set_i[i]` sets bit i, `ctl_clr_i[i]` clears it, clear wins when both are high, the change takes effect at the next edge, and no operation ever alters these bits.
- R11: Synchronous active-high reset clears the result and every flag to 0.
- R12: `flags_o` packs bit 0 carry, 1 auxiliary, 2 parity, 3 zero, 4 sign, 5 overflow, 6 direction, 7 interrupt enable, 8 single-step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode |
| a_i | input | 8 | First operand, also the shifted operand |
| b_i | input | 8 | Second operand |
| ctl_set_i | input | 3 | Per-bit set commands for the control bits |
| ctl_clr_i | input | 3 | Per-bit clear commands for the control bits |
| result_o | output | 8 | Registered result |
| flags_o | output | 9 | Packed flag word |

## Verification
The flag assertions are written as consequences of an accepted operation, so they take for granted that `valid_i`, `op_i` and the command lines are stable and known around each rising edge and that reset is held for at least one edge at start-up. The bench drives every input on the falling edge and checks on the following falling edge, keeps `valid_i` at 0 while idle, and drives out-of-range opcodes only on purpose to show they are ignored. Control commands are sometimes issued together with an operation to show both paths act in one cycle without interfering.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 4;
    localparam int CTL_N  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_ROL = 4'd7,
        OP_ROR = 4'd8
    } alu_op_e;

    localparam logic [OP_W-1:0] OP_LAST = OP_ROR;

    // control bit indices
    localparam int CTL_DIR  = 0;
    localparam int CTL_IEN  = 1;
    localparam int CTL_STEP = 2;

    // bit 0 is carry (last member)
    typedef struct packed {
        logic step;
        logic ien;
        logic dir;
        logic ovf;
        logic sign;
        logic zero;
        logic parity;
        logic aux;
        logic carry;
    } flags_t;

    typedef struct packed {
        logic carry;
        logic aux;
        logic ovf;
    } arith_fl_t;

    function automatic logic op_known(input logic [OP_W-1:0] op);
        return op <= OP_LAST;
    endfunction

    function automatic logic is_logic_op(input logic [OP_W-1:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic is_shift_op(input logic [OP_W-1:0] op);
        return (op >= OP_SHL) && (op <= OP_ROR);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_flags_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int NIB = NIB_W
) (
    input  logic         sub_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output arith_fl_t    fl_o
);
    logic [W:0]   full_w;
    logic [NIB:0] low_w;
    logic         sa, sb, sr;

    always_comb begin
        if (sub_i) begin
            full_w = {1'b0, a_i} - {1'b0, b_i};
            low_w  = {1'b0, a_i[NIB-1:0]} - {1'b0, b_i[NIB-1:0]};
        end else begin
            full_w = {1'b0, a_i} + {1'b0, b_i};
            low_w  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]};
        end
        sa = a_i[W-1];
        sb = b_i[W-1];
        sr = full_w[W-1];
        res_o       = full_w[W-1:0];
        fl_o.carry  = full_w[W];
        fl_o.aux    = low_w[NIB];
        // same-sign add or opposite-sign subtract that flips the sign
        fl_o.ovf    = (sub_i ? (sa ^ sb) : ~(sa ^ sb)) & (sr ^ sa);
    end
endmodule

// File: rtl/alu_logic_shift.sv
module alu_logic_shift
    import alu_flags_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic [W-1:0]    res_o,
    output logic            out_bit_o
);
    always_comb begin
        res_o     = '0;
        out_bit_o = 1'b0;
        case (alu_op_e'(op_i))
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_SHL: begin
                res_o     = {a_i[W-2:0], 1'b0};
                out_bit_o = a_i[W-1];
            end
            OP_SHR: begin
                res_o     = {1'b0, a_i[W-1:1]};
                out_bit_o = a_i[0];
            end
            OP_ROL: begin
                res_o     = {a_i[W-2:0], a_i[W-1]};
                out_bit_o = a_i[W-1];
            end
            OP_ROR: begin
                res_o     = {a_i[0], a_i[W-1:1]};
                out_bit_o = a_i[0];
            end
            default: begin
                res_o     = '0;
                out_bit_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_flags_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int NCTL = CTL_N
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            upd_i,
    input  logic [W-1:0]    res_i,
    input  arith_fl_t       afl_i,
    input  logic [NCTL-1:0] ctl_set_i,
    input  logic [NCTL-1:0] ctl_clr_i,
    output flags_t          flags_o
);
    arith_fl_t       afl_q;
    logic            zero_q, sign_q, par_q;
    logic [NCTL-1:0] ctl_w;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            afl_q  <= '0;
            zero_q <= 1'b0;
            sign_q <= 1'b0;
            par_q  <= 1'b0;
        end else if (upd_i) begin
            afl_q  <= afl_i;
            zero_q <= (res_i == '0);
            sign_q <= res_i[W-1];
            par_q  <= ^res_i;
        end
    end

    for (genvar g = 0; g < NCTL; g++) begin : g_ctl
        logic bit_q;
        always_ff @(posedge clk_i) begin
            if (rst_i)
                bit_q <= 1'b0;
            else if (ctl_clr_i[g])
                bit_q <= 1'b0;
            else if (ctl_set_i[g])
                bit_q <= 1'b1;
        end
        assign ctl_w[g] = bit_q;
    end

    always_comb begin
        flags_o        = '0;
        flags_o.carry  = afl_q.carry;
        flags_o.aux    = afl_q.aux;
        flags_o.ovf    = afl_q.ovf;
        flags_o.zero   = zero_q;
        flags_o.sign   = sign_q;
        flags_o.parity = par_q;
        flags_o.dir    = ctl_w[CTL_DIR];
        flags_o.ien    = ctl_w[CTL_IEN];
        flags_o.step   = ctl_w[CTL_STEP];
    end

    AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_set_i == '0 && ctl_clr_i == '0) |=> $stable(ctl_w)); // R10
    AST_CTL_DIR_SET: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctl_set_i[CTL_DIR] && !ctl_clr_i[CTL_DIR]) |=> flags_o.dir); // R10
    AST_CTL_STEP_CLR_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
        ctl_clr_i[CTL_STEP] |=> !flags_o.step); // R10
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
    import alu_flags_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             valid_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [W-1:0]     a_i,
    input  logic [W-1:0]     b_i,
    input  logic [CTL_N-1:0] ctl_set_i,
    input  logic [CTL_N-1:0] ctl_clr_i,
    output logic [W-1:0]     result_o,
    output logic [$bits(flags_t)-1:0] flags_o
);
    logic [W-1:0] as_res, ls_res, res_n, result_q;
    arith_fl_t    as_fl, fl_n;
    logic         ls_bit, upd;
    flags_t       flags_w;

    alu_addsub #(.W(W), .NIB(NIB_W)) u_addsub (
        .sub_i (op_i == OP_SUB),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (as_res),
        .fl_o  (as_fl)
    );

    alu_logic_shift #(.W(W)) u_lsh (
        .op_i      (op_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .res_o     (ls_res),
        .out_bit_o (ls_bit)
    );

    always_comb begin
        res_n = result_q;
        fl_n  = '0;
        if (op_i == OP_ADD || op_i == OP_SUB) begin
            res_n = as_res;
            fl_n  = as_fl;
        end else if (is_logic_op(op_i)) begin
            res_n = ls_res;
        end else if (is_shift_op(op_i)) begin
            res_n    = ls_res;
            fl_n.carry = ls_bit;
        end
    end

    assign upd = valid_i && op_known(op_i);

    always_ff @(posedge clk_i) begin
        if (rst_i)
            result_q <= '0;
        else if (upd)
            result_q <= res_n;
    end

    alu_flag_reg #(.W(W), .NCTL(CTL_N)) u_flags (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .upd_i     (upd),
        .res_i     (res_n),
        .afl_i     (fl_n),
        .ctl_set_i (ctl_set_i),
        .ctl_clr_i (ctl_clr_i),
        .flags_o   (flags_w)
    );

    assign result_o = result_q;
    assign flags_o  = flags_w;

    AST_ZERO_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && op_known(op_i)) |=> (flags_w.zero == (result_q == '0))); // R5
    AST_SIGN_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && op_known(op_i)) |=> (flags_w.sign == result_q[W-1])); // R5
    AST_PARITY_ODD: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && op_known(op_i)) |=> (flags_w.parity == ($countones(result_q) % 2 == 1))); // R6
    AST_LOGIC_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && is_logic_op(op_i)) |=> (!flags_w.carry && !flags_w.aux && !flags_w.ovf)); // R7
    AST_SHIFT_NO_AUX: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && is_shift_op(op_i)) |=> (!flags_w.aux && !flags_w.ovf)); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !(valid_i && op_known(op_i)) |=> ($stable(result_q) && $stable(flags_w[5:0]))); // R9
endmodule

// File: tb/sim_alu_status_unit.sv
module sim_alu_status_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] a = '0, b = '0;
    logic [2:0] cset = '0, cclr = '0;
    logic [7:0] result;
    logic [8:0] flags;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [7:0] e_res;
    logic [5:0] e_cond;   // ovf sign zero parity aux carry
    logic [2:0] e_ctl;    // step ien dir

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_status_unit u0 (
        .clk_i(clk), .rst_i(rst), .valid_i(valid), .op_i(op),
        .a_i(a), .b_i(b), .ctl_set_i(cset), .ctl_clr_i(cclr),
        .result_o(result), .flags_o(flags)
    );

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // independent reference for one operation
    task automatic model(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y);
        int s, sx, sy;
        logic [7:0] r;
        logic c, ac, ov;
        c = 0; ac = 0; ov = 0; r = e_res;
        sx = $signed(x); sy = $signed(y);
        case (o)
            0: begin s = int'(x) + int'(y); r = s[7:0]; c = s > 255;
                     ac = (int'(x % 16) + int'(y % 16)) > 15;
                     ov = (sx + sy > 127) || (sx + sy < -128); end
            1: begin s = int'(x) - int'(y); r = s[7:0]; c = x < y;
                     ac = (x % 16) < (y % 16);
                     ov = (sx - sy > 127) || (sx - sy < -128); end
            2: r = x & y;
            3: r = x | y;
            4: r = x ^ y;
            5: begin r = x << 1; c = x[7]; end
            6: begin r = x >> 1; c = x[0]; end
            7: begin r = {x[6:0], x[7]}; c = x[7]; end
            8: begin r = {x[0], x[7:1]}; c = x[0]; end
            default: ;
        endcase
        if (o <= 8) begin
            e_res  = r;
            e_cond = {ov, r[7], (r == 0), ($countones(r) % 2 == 1), ac, c};
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                         input logic v, input logic [2:0] s, input logic [2:0] cl);
        @(negedge clk);
        op = o; a = x; b = y; valid = v; cset = s; cclr = cl;
        if (v) model(o, x, y);
        e_ctl = (e_ctl | s) & ~cl;
        @(negedge clk);
        valid = 0; cset = '0; cclr = '0;
    endtask

    task automatic chk_all(input string req);
        chk(req, "result", {8'h0, result}, {8'h0, e_res});
        chk(req, "flags", {7'h0, flags}, {7'h0, e_ctl, e_cond});
    endtask

    task automatic t_reset;
        rst = 1; repeat (3) @(negedge clk); rst = 0;
        e_res = 0; e_cond = 0; e_ctl = 0;
        chk("R11", "reset result", {8'h0, result}, 16'h0);
        chk("R11", "reset flags", {7'h0, flags}, 16'h0);
    endtask

    task automatic t_add;
        apply(0, 8'h0F, 8'h01, 1, 0, 0);
        chk("R3", "0F+01 flags", {7'h0, flags}, {7'h0, 9'b000000110});
        chk("R1", "0F+01 result", {8'h0, result}, 16'h0010);
        apply(0, 8'h7F, 8'h01, 1, 0, 0);
        chk("R4", "7F+01 flags", {7'h0, flags}, {7'h0, 9'b000110110});
        apply(0, 8'hFF, 8'h01, 1, 0, 0);
        chk("R2", "FF+01 flags", {7'h0, flags}, {7'h0, 9'b000001011});
        chk_all("R5");
    endtask

    task automatic t_sub;
        apply(1, 8'h10, 8'h01, 1, 0, 0);
        chk("R3", "10-01 flags", {7'h0, flags}, {7'h0, 9'b000000010});
        apply(1, 8'h00, 8'h01, 1, 0, 0);
        chk("R2", "00-01 flags", {7'h0, flags}, {7'h0, 9'b000010011});
        chk("R1", "00-01 result", {8'h0, result}, 16'h00FF);
        apply(1, 8'h80, 8'h01, 1, 0, 0);
        chk("R4", "80-01 flags", {7'h0, flags}, {7'h0, 9'b000100110});
    endtask

    task automatic t_logic;
        apply(0, 8'hFF, 8'hFF, 1, 0, 0);     // leaves carry and aux set
        apply(2, 8'hF0, 8'h3C, 1, 0, 0);
        chk("R7", "AND flags", {7'h0, flags}, {7'h0, 9'b000000000});
        chk("R1", "AND result", {8'h0, result}, 16'h0030);
        apply(3, 8'h80, 8'h01, 1, 0, 0);
        chk("R6", "OR flags", {7'h0, flags}, {7'h0, 9'b000010000});
        apply(4, 8'hAA, 8'hAA, 1, 0, 0);
        chk("R5", "XOR zero flags", {7'h0, flags}, {7'h0, 9'b000001000});
        apply(4, 8'h01, 8'h00, 1, 0, 0);
        chk("R6", "XOR odd parity", {7'h0, flags}, {7'h0, 9'b000000100});
    endtask

    task automatic t_shift;
        apply(5, 8'h81, 8'hFF, 1, 0, 0);
        chk("R8", "SHL result", {8'h0, result}, 16'h0002);
        chk("R8", "SHL carry", {15'h0, flags[0]}, 16'h1);
        apply(6, 8'h81, 8'h00, 1, 0, 0);
        chk("R8", "SHR result", {8'h0, result}, 16'h0040);
        chk("R8", "SHR carry", {15'h0, flags[0]}, 16'h1);
        apply(7, 8'h81, 8'h00, 1, 0, 0);
        chk("R8", "ROL result", {8'h0, result}, 16'h0003);
        apply(8, 8'h02, 8'h00, 1, 0, 0);
        chk("R8", "ROR result/carry", {7'h0, flags[0], result}, 16'h0001);
        chk_all("R8");
    endtask

    task automatic t_ctrl;
        apply(0, 8'h00, 8'h00, 0, 3'b001, 0);
        chk("R10", "dir set", {7'h0, flags}, {7'h0, e_ctl, e_cond});
        chk("R12", "dir bit position", {15'h0, flags[6]}, 16'h1);
        apply(0, 8'hFF, 8'h01, 1, 3'b110, 0);
        chk("R10", "set with add", {13'h0, flags[8:6]}, 16'h7);
        chk_all("R2");
        apply(1, 8'h05, 8'h05, 1, 0, 0);
        chk("R10", "sub keeps control", {13'h0, flags[8:6]}, 16'h7);
        apply(0, 0, 0, 0, 3'b100, 3'b101);
        chk("R10", "clear wins", {13'h0, flags[8:6]}, 16'h2);
    endtask

    task automatic t_hold;
        logic [7:0] r0; logic [8:0] f0;
        apply(1, 8'h00, 8'h03, 1, 0, 0);
        r0 = result; f0 = flags;
        apply(0, 8'h12, 8'h34, 0, 0, 0);
        chk("R9", "no valid hold", {r0, 8'h0} | {8'h0, 8'h0}, {result, 8'h0});
        chk("R9", "no valid flags", {7'h0, flags}, {7'h0, f0});
        apply(4'd12, 8'h00, 8'h00, 1, 0, 0);
        chk("R9", "unknown op result", {8'h0, result}, {8'h0, r0});
        chk("R9", "unknown op flags", {7'h0, flags}, {7'h0, f0});
    endtask

    task automatic t_sweep;
        logic [7:0] lf = 8'h5A;
        for (int i = 0; i < 180; i++) begin
            logic [7:0] x, y;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            x = lf ^ 8'(i * 37);
            y = {lf[3:0], lf[7:4]} + 8'(i);
            apply(4'(i % 9), x, y, 1, 0, 0);
            chk_all(i % 9 < 2 ? "R4" : (i % 9 < 5 ? "R7" : "R8"));
        end
    endtask

    initial begin
        e_res = 0; e_cond = 0; e_ctl = 0;
        repeat (2) @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_ctrl();
        t_hold();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule